// File: doc/BRIEF.md
# Oversampling Accumulate, Round and Shift Unit

This block follows a 12-bit converter and turns a run of consecutive samples into one wider result. It sums a power-of-two number of accepted samples and shifts the total right by a programmable amount. The bits that the shift removes round the result to the nearest value. Only the low 16 bits of the rounded value are kept. Nothing saturates, so a large sum with a small shift wraps. The ratio and the shift are chosen independently, so the result can be a true average, a scaled sum or anything in between.

A small controller has two states. `ST_IDLE` means no group is open. `ST_ACCUM` means a group is collecting samples. Transition START (`ST_IDLE` to `ST_ACCUM`) happens when the first sample of a group is accepted; the ratio and shift inputs are captured at that moment. Transition DONE (`ST_ACCUM` to `ST_IDLE`) happens when the final sample of the group is accepted; the rounded result is registered and flagged on the next clock. Transition ABORT (any state to `ST_IDLE`) happens whenever `enable` is low; the partial sum and the sample count are discarded. In `ST_ACCUM` each accepted sample that is not the last keeps the state.

Top module: `ovs_accum_unit`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_result` is 0.
- R2: Ratio select code c (0 to 7) makes one result from exactly 2^(c+1) accepted samples. Code 0 means 2 samples and code 7 means 256 samples. No result appears before the final sample of a group.
- R3: The result is the sum of the group's samples shifted right by the shift select value. A shift of 0 gives the plain sum with no rounding.
- R4: For a shift s from 1 to 8, 2^(s-1) is added to the sum at 21-bit width before the shift. An exact half therefore rounds up, and a carry out of the top sum bit is kept.
- R5: Shift select values 9 to 15 behave exactly like 8.
- R6: Only bits 15:0 of the shifted and rounded value appear on `out_result`. Higher bits are dropped without saturation. For example, 256 samples of 4095 with shift 0 give 0xFF00.
- R7: `out_valid` is high for exactly one cycle, on the clock after the final sample of a group is accepted. `out_result` holds that group's value during that cycle.
- R8: While `enable` is low, samples are not accepted, no result is produced, and any partial group is discarded. The first group after `enable` returns contains only new samples.
- R9: Changes to the ratio or shift select while a group is open do not affect that group. They apply from the next group.
- R10: Cycles with `sample_valid` low add nothing to the sum and do not advance the count, whatever `sample_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Accepts samples when high; low clears any partial group |
| sample_valid | input | 1 | Marks `sample_data` as a new sample this cycle |
| sample_data | input | 12 | Converter sample, unsigned |
| ratio_sel | input | 3 | Group size code: 2^(code+1) samples |
| shift_sel | input | 4 | Right shift amount; 9 to 15 act as 8 |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_result | output | 16 | Rounded, shifted and truncated group result |

## Verification
The hardest case to reach from the ports is the top of the range. Here the 20-bit sum is close to full scale, the rounding carry matters, and the shifted value is wider than 16 bits, so truncation has to be seen rather than assumed. The bench reaches it by streaming 256 full-scale samples back to back with shift values 0, 3 and 4. Each run is checked against a model of round-then-truncate built in the bench. A second case that is hard to reach is a configuration change in the middle of a group. The bench opens a 4-sample group and then switches to a 2-sample ratio halfway through. It checks that no result appears after the second sample and that the old shift is still applied.

// File: rtl/ovs_pkg.sv
package ovs_pkg;

    // Default geometry shared by all parts of the unit
    localparam int SAMPLE_W_DEF  = 12;
    localparam int RCODE_W_DEF   = 3;
    localparam int SCODE_W_DEF   = 4;
    localparam int OUT_W_DEF     = 16;
    localparam int MAX_SHIFT_DEF = 8;

    // Group controller states
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ACCUM = 1'b1
    } ovs_state_e;

endpackage

// File: rtl/ovs_ctrl.sv
module ovs_ctrl
    import ovs_pkg::*;
#(
    parameter int RCODE_W   = RCODE_W_DEF,
    parameter int SCODE_W   = SCODE_W_DEF,
    parameter int MAX_SHIFT = MAX_SHIFT_DEF,
    localparam int CNT_W    = (1 << RCODE_W) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               sample_valid,
    input  logic [RCODE_W-1:0] ratio_sel,
    input  logic [SCODE_W-1:0] shift_sel,
    output logic               take,
    output logic               last,
    output logic [SCODE_W-1:0] shift_eff
);

    ovs_state_e         state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [RCODE_W-1:0] ratio_q;
    logic [SCODE_W-1:0] shift_q;
    logic [RCODE_W-1:0] ratio_eff;
    logic [SCODE_W-1:0] shift_clamped;
    logic [CNT_W-1:0]   limit;

    // Saturate the requested shift at the maximum supported amount
    assign shift_clamped = (shift_sel > SCODE_W'(MAX_SHIFT)) ? SCODE_W'(MAX_SHIFT) : shift_sel;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state: START, DONE, ABORT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (enable && sample_valid) state_d = ST_ACCUM;   // START
            end
            ST_ACCUM: begin
                if (!enable)   state_d = ST_IDLE;                 // ABORT
                else if (last) state_d = ST_IDLE;                 // DONE
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs: the live config applies when idle, the captured one inside a group
    always_comb begin
        take      = enable && sample_valid;
        ratio_eff = ratio_q;
        shift_eff = shift_q;
        unique case (state_q)
            ST_IDLE: begin
                ratio_eff = ratio_sel;
                shift_eff = shift_clamped;
            end
            ST_ACCUM: begin
                ratio_eff = ratio_q;
                shift_eff = shift_q;
            end
            default: ;
        endcase
        limit = (CNT_W'(2) << ratio_eff) - CNT_W'(1);
        last  = take && (cnt_q == limit);
    end

    // Group bookkeeping: sample count and captured config
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ratio_q <= '0;
            shift_q <= '0;
        end else if (!enable) begin
            cnt_q <= '0;
        end else if (take) begin
            if (state_q == ST_IDLE) begin
                ratio_q <= ratio_sel;
                shift_q <= shift_clamped;
            end
            cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
        end
    end

    // Count never passes the group size while a group is open
    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACCUM) |-> (cnt_q <= limit));

    // Captured config is frozen until the group ends
    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACCUM && enable && !last) |=> ($stable(ratio_q) && $stable(shift_q)));

    // Dropping enable returns to idle with an empty count
    assert_abort_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state_q == ST_IDLE && cnt_q == '0));

    // Captured shift is already clamped
    assert_shift_clamped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        shift_q <= SCODE_W'(MAX_SHIFT));

endmodule

// File: rtl/ovs_accum.sv
module ovs_accum
    import ovs_pkg::*;
#(
    parameter int SAMPLE_W = SAMPLE_W_DEF,
    parameter int RCODE_W  = RCODE_W_DEF,
    localparam int ACC_W   = SAMPLE_W + (1 << RCODE_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                take,
    input  logic                last,
    input  logic [SAMPLE_W-1:0] sample_data,
    output logic [ACC_W-1:0]    sum_total
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum_wide;

    assign sum_wide  = {1'b0, acc_q} + (ACC_W+1)'(sample_data);
    assign sum_total = sum_wide[ACC_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       acc_q <= '0;
        else if (!enable) acc_q <= '0;
        else if (take)    acc_q <= last ? '0 : sum_total;
    end

    // The accumulator is sized for the largest group, so it never wraps
    assert_acc_fits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !sum_wide[ACC_W]);

    // Disabled cycles leave an empty accumulator
    assert_acc_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (acc_q == '0));

endmodule

// File: rtl/ovs_round_shift.sv
module ovs_round_shift
    import ovs_pkg::*;
#(
    parameter int ACC_W   = SAMPLE_W_DEF + (1 << RCODE_W_DEF),
    parameter int SCODE_W = SCODE_W_DEF,
    parameter int OUT_W   = OUT_W_DEF,
    localparam int RND_W  = ACC_W + 1
) (
    input  logic [ACC_W-1:0]   sum_in,
    input  logic [SCODE_W-1:0] shift_amt,
    output logic [OUT_W-1:0]   result
);

    logic [RND_W-1:0] bias;
    logic [RND_W-1:0] biased;
    logic [RND_W-1:0] shifted;

    always_comb begin
        // Half of one output LSB, only when something is shifted out
        if (shift_amt != '0) bias = RND_W'(1) << (shift_amt - SCODE_W'(1));
        else                 bias = '0;
        biased  = {1'b0, sum_in} + bias;
        shifted = biased >> shift_amt;
        result  = shifted[OUT_W-1:0];
    end

endmodule

// File: rtl/ovs_accum_unit.sv
module ovs_accum_unit
    import ovs_pkg::*;
#(
    parameter int SAMPLE_W  = SAMPLE_W_DEF,
    parameter int RCODE_W   = RCODE_W_DEF,
    parameter int SCODE_W   = SCODE_W_DEF,
    parameter int OUT_W     = OUT_W_DEF,
    parameter int MAX_SHIFT = MAX_SHIFT_DEF,
    localparam int ACC_W    = SAMPLE_W + (1 << RCODE_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                sample_valid,
    input  logic [SAMPLE_W-1:0] sample_data,
    input  logic [RCODE_W-1:0]  ratio_sel,
    input  logic [SCODE_W-1:0]  shift_sel,
    output logic                out_valid,
    output logic [OUT_W-1:0]    out_result
);

    logic               take;
    logic               last;
    logic [SCODE_W-1:0] shift_eff;
    logic [ACC_W-1:0]   sum_total;
    logic [OUT_W-1:0]   rounded;

    ovs_ctrl #(
        .RCODE_W   (RCODE_W),
        .SCODE_W   (SCODE_W),
        .MAX_SHIFT (MAX_SHIFT)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .sample_valid (sample_valid),
        .ratio_sel    (ratio_sel),
        .shift_sel    (shift_sel),
        .take         (take),
        .last         (last),
        .shift_eff    (shift_eff)
    );

    ovs_accum #(
        .SAMPLE_W (SAMPLE_W),
        .RCODE_W  (RCODE_W)
    ) u_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .take        (take),
        .last        (last),
        .sample_data (sample_data),
        .sum_total   (sum_total)
    );

    ovs_round_shift #(
        .ACC_W   (ACC_W),
        .SCODE_W (SCODE_W),
        .OUT_W   (OUT_W)
    ) u_round (
        .sum_in    (sum_total),
        .shift_amt (shift_eff),
        .result    (rounded)
    );

    // Registered result and strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= last;
            if (last) out_result <= rounded;
        end
    end

    // The strobe lasts one cycle, since every group has at least two samples
    assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // A result only follows an accepted sample
    assert_valid_follows_sample_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(enable && sample_valid));

    // No result while disabled
    assert_no_valid_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !out_valid);

    // The result holds between strobes
    assert_result_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid && !last |=> $stable(out_result));

endmodule

// File: tb/test_ovs_accum_unit.sv
module test_ovs_accum_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        sample_valid = 1'b0;
    logic [11:0] sample_data = '0;
    logic [2:0]  ratio_sel = '0;
    logic [3:0]  shift_sel = '0;
    logic        out_valid;
    logic [15:0] out_result;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    always #4 clk = ~clk;   // 125 MHz

    ovs_accum_unit i_ovs_accum_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .sample_valid (sample_valid),
        .sample_data  (sample_data),
        .ratio_sel    (ratio_sel),
        .shift_sel    (shift_sel),
        .out_valid    (out_valid),
        .out_result   (out_result)
    );

    function automatic logic [15:0] model(input longint sum, input int shcode);
        int sh = (shcode > 8) ? 8 : shcode;
        longint v = sum + ((sh != 0) ? (longint'(1) << (sh - 1)) : 0);
        return 16'(v >> sh);
    endfunction

    function automatic logic [11:0] gen(input int seed, input int i);
        return 12'((seed * 131 + i * 2897 + 17) % 4096);
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [11:0] v);
        @(negedge clk);
        sample_valid = 1'b1;
        sample_data  = v;
    endtask

    task automatic idle_junk(input int n);
        repeat (n) begin
            @(negedge clk);
            sample_valid = 1'b0;
            sample_data  = 12'hFFF;
        end
    endtask

    // Full group: cval >= 0 gives a constant sample, otherwise generated values
    task automatic run_group(input string req, input int code, input int sh,
                             input int seed, input int cval, input bit gaps);
        int n = 2 << code;
        longint sum = 0;
        ratio_sel = 3'(code);
        shift_sel = 4'(sh);
        for (int i = 0; i < n; i++) begin
            logic [11:0] v = (cval >= 0) ? 12'(cval) : gen(seed, i);
            sum += v;
            if (i == n - 1) begin
                @(negedge clk);
                check({req, " no early result"}, out_valid, 0);
                sample_valid = 1'b1;
                sample_data  = v;
            end else begin
                push(v);
                if (gaps) idle_junk(1);
            end
        end
        @(negedge clk);
        sample_valid = 1'b0;
        check({req, " valid"}, out_valid, 1);
        check({req, " result"}, out_result, model(sum, sh));
        @(negedge clk);
        check("R7 single-cycle strobe", out_valid, 0);
    endtask

    task automatic t_reset;
        check("R1 valid at reset", out_valid, 0);
        check("R1 result at reset", out_result, 0);
    endtask

    task automatic t_ratio_sweep;
        for (int c = 0; c < 8; c++) run_group("R2 ratio sweep", c, c + 1, c, -1, (c % 2) == 1);
    endtask

    task automatic t_plain_sum;
        run_group("R3 shift 0 pair", 0, 0, 0, 100, 0);
        run_group("R3 shift 0 eight", 2, 0, 9, -1, 0);
        run_group("R3 shift 5", 4, 5, 3, -1, 0);
    endtask

    task automatic t_rounding;
        // sum 1, shift 1: exact half rounds up to 1
        ratio_sel = 3'd0; shift_sel = 4'd1;
        push(12'd0); push(12'd1);
        @(negedge clk); sample_valid = 1'b0;
        check("R4 half rounds up", out_result, 1);
        // sum 1, shift 2: below half rounds to 0
        shift_sel = 4'd2;
        push(12'd1); push(12'd0);
        @(negedge clk); sample_valid = 1'b0;
        check("R4 below half", out_result, 0);
        // sum 6, shift 2: 1.5 rounds up to 2
        push(12'd3); push(12'd3);
        @(negedge clk); sample_valid = 1'b0;
        check("R4 1.5 rounds to 2", out_result, 2);
        // carry through all kept bits: 2*4095 = 8190, shift 8 -> 32
        run_group("R4 carry", 0, 8, 0, 4095, 0);
    endtask

    task automatic t_shift_clamp;
        run_group("R5 shift 9", 3, 9, 21, -1, 0);
        run_group("R5 shift 12", 3, 12, 22, -1, 0);
        run_group("R5 shift 15", 1, 15, 23, -1, 0);
    endtask

    task automatic t_truncate;
        run_group("R6 full scale shift 0", 7, 0, 0, 4095, 0);
        run_group("R6 full scale shift 3", 7, 3, 0, 4095, 0);
        run_group("R6 full scale shift 4", 7, 4, 0, 4095, 0);
        run_group("R6 128 samples shift 1", 6, 1, 5, -1, 0);
    endtask

    task automatic t_enable_abort;
        ratio_sel = 3'd1; shift_sel = 4'd0;
        push(12'd1000); push(12'd1000); push(12'd1000);
        @(negedge clk);
        enable = 1'b0; sample_valid = 1'b1; sample_data = 12'd500;
        @(negedge clk);
        check("R8 no result while disabled", out_valid, 0);
        enable = 1'b1; sample_valid = 1'b0;
        push(12'd7);
        @(negedge clk); sample_valid = 1'b0;
        check("R8 partial group dropped", out_valid, 0);
        push(12'd8); push(12'd9); push(12'd10);
        @(negedge clk); sample_valid = 1'b0;
        check("R8 new group valid", out_valid, 1);
        check("R8 new group result", out_result, 34);
    endtask

    task automatic t_mid_change;
        ratio_sel = 3'd1; shift_sel = 4'd2;
        push(12'd400); push(12'd401);
        ratio_sel = 3'd0; shift_sel = 4'd0;
        @(negedge clk); sample_valid = 1'b0;
        check("R9 old ratio kept", out_valid, 0);
        push(12'd402); push(12'd403);
        @(negedge clk); sample_valid = 1'b0;
        check("R9 group valid", out_valid, 1);
        check("R9 old shift kept", out_result, model(1606, 2));
        push(12'd50); push(12'd60);
        @(negedge clk); sample_valid = 1'b0;
        check("R9 new config valid", out_valid, 1);
        check("R9 new config result", out_result, 110);
    endtask

    task automatic t_gaps;
        // valid-low cycles carry junk data that must not count
        ratio_sel = 3'd0; shift_sel = 4'd0;
        push(12'd11); idle_junk(3); push(12'd22);
        @(negedge clk); sample_valid = 1'b0;
        check("R10 junk ignored valid", out_valid, 1);
        check("R10 junk ignored result", out_result, 33);
        run_group("R10 gapped group", 2, 1, 44, -1, 1);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        enable = 1'b1;
        t_ratio_sweep();
        t_plain_sum();
        t_rounding();
        t_shift_clamp();
        t_truncate();
        t_enable_abort();
        t_mid_change();
        t_gaps();
        idle_junk(2);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule